// File: doc/BRIEF.md
# Two-Channel Converter Fault Sequencer

This block turns the protection comparator flags of a two-channel synchronous step-down controller into per-channel gate-drive and soft-start commands. For each channel it has four named states. `CH_IDLE` means the channel is off and its output is discharging. `CH_RUN` lets the PWM drive both gates. `CH_UVL` is the under-voltage latch, with both gates off. `CH_OVL` is the over-voltage latch, with the high-side gate off and the low-side gate forced on. Each state fixes four outputs: a gate permit, a forced low-side command, a discharge-switch enable and a soft-start capacitor reset.

Each fault class has its own timer. Under-voltage counts oscillator ticks. Over-voltage counts system clocks. The cascade low-side overcurrent on the second channel uses a short clock count. Supply lockout stops the channels at once and never latches. A latched channel leaves its latch only under the clear rules, and those rules depend on the level of the mode pin. A channel restarts only after its output has been discharged.

The transitions are:
- `CH_IDLE`→`CH_RUN` when the channel is enabled, its output is discharged and no lockout is present.
- `CH_RUN`→`CH_IDLE` on lockout, on disable, or on a cascade trip.
- `CH_RUN`→`CH_OVL` when the over-voltage timer expires. This takes precedence over the next transition.
- `CH_RUN`→`CH_UVL` when the under-voltage timer expires.
- `CH_UVL`/`CH_OVL`→`CH_IDLE` on a latch clear.

Top module: `conv_fault_guard`

## Requirements
- R1: Out of reset every channel is in `CH_IDLE`, and the outputs read as the pattern {permit, ls_force, dis_en, ss_reset} = 0,0,1,1.
- R2: An idle channel moves to `CH_RUN`, giving the pattern 1,0,0,0, one clock after it is sampled enabled, with `out_low` high and both lockouts low. While `out_low` is low it stays idle.
- R3: If `uv_flag` stays high in `CH_RUN` for UV_TICKS cycles in which `osc_tick` is high, the channel latches in `CH_UVL`, giving 0,0,1,1. Cycles without a tick do not count. A latched channel does not restart, even when it is enabled and discharged.
- R4: If `uv_flag` drops before the under-voltage timer expires, the timer returns to zero, and a full UV_TICKS new ticks are then needed.
- R5: If `ov_flag` stays high in `CH_RUN` for OV_CYC consecutive clocks, the channel latches in `CH_OVL`, giving 0,1,1,1. A shorter pulse has no effect.
- R6: Either lockout input forces every running channel to `CH_IDLE` on the next clock. The channel starts again by R2 once the lockout clears, with no latch set.
- R7: Input-supply lockout (`uvlo_vin`) clears both latches. Internal-supply lockout (`uvlo_reg`) leaves them set.
- R8: A latch also clears when `mode_dual` is 0 and both enables are 0 at the same clock. With `mode_dual` at 1, dropping both enables leaves the latch set. With one enable still at 1, the latch stays set in either mode.
- R9: A disabled channel goes to `CH_IDLE` on the next clock. Once enabled again, it restarts only when `out_low` is high.
- R10: With `cascade_sel` at 1, `oc_flag` high for OC_CYC consecutive clocks while the last channel runs sends every running channel to `CH_IDLE` with no latch. With `cascade_sel` at 0, `oc_flag` is ignored.
- R11: A fault on one channel leaves the other channel in `CH_RUN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | NCH | Per-channel enable |
| mode_dual | input | 1 | Mode pin level: 1 dual, 0 tracking (DDR) |
| cascade_sel | input | 1 | Last channel uses the cascade overcurrent option |
| uv_flag | input | NCH | Feedback below the under-voltage threshold |
| ov_flag | input | NCH | Feedback above the over-voltage threshold |
| oc_flag | input | 1 | Low-side overcurrent of the last channel |
| uvlo_vin | input | 1 | Input-supply lockout |
| uvlo_reg | input | 1 | Internal 5 V supply lockout |
| osc_tick | input | 1 | One-clock pulse per oscillator period |
| out_low | input | NCH | Output discharged below the restart level |
| drv_permit | output | NCH | PWM may drive both gates |
| ls_force | output | NCH | Force the low-side gate on |
| dis_en | output | NCH | Output discharge switch on |
| ss_reset | output | NCH | Discharge the soft-start capacitor |

## Verification
The bench builds the block with UV_TICKS=16, OV_CYC=10 and OC_CYC=4. With these values each timer expires within a few dozen clocks, so the exact expiry clock and the clock just before it can both be checked for every fault class. The short windows also let random glitches of every length below OV_CYC and UV_TICKS be applied, to confirm that nothing latches early. The default values, 4096 ticks and about 20 µs of clocks, differ only in the counter limits.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_RUN  = 2'd1,
        CH_UVL  = 2'd2,
        CH_OVL  = 2'd3
    } ch_state_t;
endpackage

// File: rtl/cfg_fault_timer.sv
// Persistence counter: counts qualifying steps while armed and
// clears as soon as the arm condition drops.
module cfg_fault_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic step,
    output logic expire
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt;

    assign expire = arm && step && (cnt == W'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!arm) begin
            cnt <= '0;
        end else if (step && !expire) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/cfg_chan_fsm.sv
// Per-channel sequencing state machine.
module cfg_chan_fsm
    import cfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic out_low,
    input  logic uvlo_any,
    input  logic latch_clr,
    input  logic uv_exp,
    input  logic ov_exp,
    input  logic oc_trip,
    output logic in_run,
    output logic drv_permit,
    output logic ls_force,
    output logic dis_en,
    output logic ss_reset
);
    ch_state_t st, st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= CH_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            CH_IDLE: if (en && out_low && !uvlo_any) st_nx = CH_RUN;
            CH_RUN: begin
                if (uvlo_any || !en || oc_trip) st_nx = CH_IDLE;
                else if (ov_exp)                st_nx = CH_OVL;
                else if (uv_exp)                st_nx = CH_UVL;
            end
            CH_UVL:  if (latch_clr) st_nx = CH_IDLE;
            CH_OVL:  if (latch_clr) st_nx = CH_IDLE;
            default: st_nx = CH_IDLE;
        endcase
    end

    always_comb begin
        in_run     = 1'b0;
        drv_permit = 1'b0;
        ls_force   = 1'b0;
        dis_en     = 1'b1;
        ss_reset   = 1'b1;
        unique case (st)
            CH_IDLE: ;
            CH_RUN: begin
                in_run     = 1'b1;
                drv_permit = 1'b1;
                dis_en     = 1'b0;
                ss_reset   = 1'b0;
            end
            CH_UVL:  ;
            CH_OVL:  ls_force = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/conv_fault_guard.sv
module conv_fault_guard #(
    parameter int NCH      = 2,
    parameter int UV_TICKS = 4096,
    parameter int OV_CYC   = 1000,
    parameter int OC_CYC   = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] en,
    input  logic           mode_dual,
    input  logic           cascade_sel,
    input  logic [NCH-1:0] uv_flag,
    input  logic [NCH-1:0] ov_flag,
    input  logic           oc_flag,
    input  logic           uvlo_vin,
    input  logic           uvlo_reg,
    input  logic           osc_tick,
    input  logic [NCH-1:0] out_low,
    output logic [NCH-1:0] drv_permit,
    output logic [NCH-1:0] ls_force,
    output logic [NCH-1:0] dis_en,
    output logic [NCH-1:0] ss_reset
);
    localparam int CASC_CH = NCH - 1;

    logic           uvlo_any;
    logic           latch_clr;
    logic           oc_trip;
    logic [NCH-1:0] in_run;
    logic [NCH-1:0] uv_exp;
    logic [NCH-1:0] ov_exp;

    assign uvlo_any  = uvlo_vin | uvlo_reg;
    assign latch_clr = uvlo_vin | (~mode_dual & ~|en);

    cfg_fault_timer #(.LIMIT(OC_CYC)) u_oc_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (cascade_sel & oc_flag & in_run[CASC_CH]),
        .step   (1'b1),
        .expire (oc_trip)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        cfg_fault_timer #(.LIMIT(UV_TICKS)) u_uv_tmr (
            .clk    (clk),
            .rst_n  (rst_n),
            .arm    (uv_flag[i] & in_run[i]),
            .step   (osc_tick),
            .expire (uv_exp[i])
        );

        cfg_fault_timer #(.LIMIT(OV_CYC)) u_ov_tmr (
            .clk    (clk),
            .rst_n  (rst_n),
            .arm    (ov_flag[i] & in_run[i]),
            .step   (1'b1),
            .expire (ov_exp[i])
        );

        cfg_chan_fsm u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .en         (en[i]),
            .out_low    (out_low[i]),
            .uvlo_any   (uvlo_any),
            .latch_clr  (latch_clr),
            .uv_exp     (uv_exp[i]),
            .ov_exp     (ov_exp[i]),
            .oc_trip    (oc_trip),
            .in_run     (in_run[i]),
            .drv_permit (drv_permit[i]),
            .ls_force   (ls_force[i]),
            .dis_en     (dis_en[i]),
            .ss_reset   (ss_reset[i])
        );
    end
endmodule

// File: rtl/conv_fault_guard_chk.sv
module conv_fault_guard_chk #(
    parameter int NCH = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] en,
    input logic           mode_dual,
    input logic           uvlo_vin,
    input logic           uvlo_reg,
    input logic [NCH-1:0] out_low,
    input logic [NCH-1:0] drv_permit,
    input logic [NCH-1:0] ls_force,
    input logic [NCH-1:0] dis_en,
    input logic [NCH-1:0] ss_reset
);
    p_uvlo_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (uvlo_vin || uvlo_reg) |=> (drv_permit == '0));

    for (genvar i = 0; i < NCH; i++) begin : g_c
        p_ovl_pattern_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ls_force[i] |-> (!drv_permit[i] && dis_en[i] && ss_reset[i]));

        p_disable_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !en[i] |=> !drv_permit[i]);

        p_restart_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(drv_permit[i]) |-> $past(out_low[i] && en[i]));

        p_latch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (ls_force[i] && !uvlo_vin && !(!mode_dual && en == '0)) |=> ls_force[i]);
    end
endmodule

bind conv_fault_guard conv_fault_guard_chk #(.NCH(NCH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .mode_dual  (mode_dual),
    .uvlo_vin   (uvlo_vin),
    .uvlo_reg   (uvlo_reg),
    .out_low    (out_low),
    .drv_permit (drv_permit),
    .ls_force   (ls_force),
    .dis_en     (dis_en),
    .ss_reset   (ss_reset)
);

// File: tb/sim_conv_fault_guard.sv
module sim_conv_fault_guard;
    localparam int NCH = 2;
    localparam int UVT = 16;
    localparam int OVC = 10;
    localparam int OCC = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0] en = '0, uv_flag = '0, ov_flag = '0, out_low = '0;
    logic mode_dual = 1'b1, cascade_sel = 1'b0, oc_flag = 1'b0;
    logic uvlo_vin = 1'b0, uvlo_reg = 1'b0, osc_tick = 1'b1;
    logic [NCH-1:0] drv_permit, ls_force, dis_en, ss_reset;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    conv_fault_guard #(.NCH(NCH), .UV_TICKS(UVT), .OV_CYC(OVC), .OC_CYC(OCC)) u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .mode_dual(mode_dual),
        .cascade_sel(cascade_sel), .uv_flag(uv_flag), .ov_flag(ov_flag),
        .oc_flag(oc_flag), .uvlo_vin(uvlo_vin), .uvlo_reg(uvlo_reg),
        .osc_tick(osc_tick), .out_low(out_low), .drv_permit(drv_permit),
        .ls_force(ls_force), .dis_en(dis_en), .ss_reset(ss_reset)
    );

    // Expected {permit, ls_force, dis_en, ss_reset}: 0 idle, 1 run, 2 uv latch, 3 ov latch
    function automatic logic [3:0] pat(input int kind);
        case (kind)
            1:       return 4'b1000;
            2:       return 4'b0011;
            3:       return 4'b0111;
            default: return 4'b0011;
        endcase
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int ch, input int kind);
        logic [3:0] act;
        act = {drv_permit[ch], ls_force[ch], dis_en[ch], ss_reset[ch]};
        n_chk++;
        if (act !== pat(kind)) begin
            n_bad++;
            $display("FAIL %s ch%0d actual=%b expected=%b t=%0t", tag, ch, act, pat(kind), $time);
        end
    endtask

    task automatic bring_up();
        en = 2'b11; out_low = 2'b11;
        tick(1);
        out_low = 2'b00;
    endtask

    initial begin
        void'($urandom(32'd2718));
        tick(3);
        rst_n = 1'b1;
        tick(1);
        chk("R1", 0, 0); chk("R1", 1, 0);

        // R2: start gated by discharge
        en = 2'b11;
        tick(3);
        chk("R2", 0, 0); chk("R2", 1, 0);
        out_low = 2'b11;
        tick(1);
        chk("R2", 0, 1); chk("R2", 1, 1);
        out_low = 2'b00;

        // R5: random over-voltage glitches shorter than the window
        for (int k = 0; k < 12; k++) begin
            int ch = $urandom % 2;
            int len = 1 + ($urandom % (OVC - 1));
            ov_flag[ch] = 1'b1;
            tick(len);
            ov_flag[ch] = 1'b0;
            tick(1);
            chk("R5", ch, 1);
        end
        // R4: random under-voltage glitches shorter than the window
        for (int k = 0; k < 8; k++) begin
            int ch = $urandom % 2;
            int len = 1 + ($urandom % (UVT - 1));
            uv_flag[ch] = 1'b1;
            tick(len);
            uv_flag[ch] = 1'b0;
            tick(1);
            chk("R4", ch, 1);
        end

        // R5: full over-voltage window on ch0
        ov_flag[0] = 1'b1;
        tick(OVC - 1);
        chk("R5", 0, 1);
        tick(1);
        chk("R5", 0, 3);
        chk("R11", 1, 1);
        ov_flag[0] = 1'b0;

        // R8: dual mode, enables low keeps latch; mode low clears
        en = 2'b00;
        tick(3);
        chk("R8", 0, 3);
        chk("R9", 1, 0);
        mode_dual = 1'b0;
        tick(1);
        chk("R8", 0, 0);
        mode_dual = 1'b1;

        // R3 / R4 on ch1
        bring_up();
        chk("R2", 0, 1); chk("R2", 1, 1);
        osc_tick = 1'b0;
        uv_flag[1] = 1'b1;
        tick(40);
        chk("R3", 1, 1);
        uv_flag[1] = 1'b0;
        osc_tick = 1'b1;
        tick(1);
        uv_flag[1] = 1'b1;
        tick(10);
        uv_flag[1] = 1'b0;
        tick(1);
        uv_flag[1] = 1'b1;
        tick(UVT - 1);
        chk("R4", 1, 1);
        tick(1);
        chk("R3", 1, 2);
        chk("R11", 0, 1);
        uv_flag[1] = 1'b0;
        out_low = 2'b10;
        tick(4);
        chk("R3", 1, 2);

        // R6 / R7: internal lockout keeps latch, input lockout clears it
        out_low = 2'b11;
        uvlo_reg = 1'b1;
        tick(1);
        chk("R6", 0, 0);
        uvlo_reg = 1'b0;
        tick(1);
        chk("R6", 0, 1);
        tick(2);
        chk("R7", 1, 2);
        uvlo_vin = 1'b1;
        tick(1);
        chk("R6", 0, 0);
        uvlo_vin = 1'b0;
        tick(1);
        chk("R7", 1, 1);
        chk("R6", 0, 1);
        out_low = 2'b00;

        // R10: cascade overcurrent
        oc_flag = 1'b1;
        tick(10);
        chk("R10", 0, 1); chk("R10", 1, 1);
        cascade_sel = 1'b1;
        tick(OCC - 1);
        chk("R10", 1, 1);
        tick(1);
        chk("R10", 0, 0); chk("R10", 1, 0);
        oc_flag = 1'b0;
        tick(2);
        chk("R10", 1, 0);
        out_low = 2'b11;
        tick(1);
        chk("R10", 0, 1); chk("R10", 1, 1);
        out_low = 2'b00;
        cascade_sel = 1'b0;

        // R9: disable and restart gating
        en[0] = 1'b0;
        tick(1);
        chk("R9", 0, 0);
        chk("R11", 1, 1);
        en[0] = 1'b1;
        tick(3);
        chk("R9", 0, 0);
        out_low[0] = 1'b1;
        tick(1);
        chk("R9", 0, 1);
        out_low[0] = 1'b0;

        // R8: tracking mode, one enable high keeps latch, both low clears
        mode_dual = 1'b0;
        ov_flag[0] = 1'b1;
        tick(OVC);
        chk("R5", 0, 3);
        ov_flag[0] = 1'b0;
        en = 2'b10;
        tick(2);
        chk("R8", 0, 3);
        en = 2'b00;
        tick(1);
        chk("R8", 0, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule